// File: doc/BRIEF.md
# Interlocked Four-Phase Read Link

This block carries single-word reads across a shared set of address/data lines that has no bus clock. An initiating side and a memory side each run on their own local clock. The initiating side places an address on the shared lines and raises a read-request line. The memory side captures the address, runs a read of fixed latency, and then returns the word on the same lines with a data-ready line. A single acknowledge line confirms each step in both directions, so every edge of the exchange is fully interlocked.

Each side sees the other side's control lines only through a two-stage synchronizer. Both sides expose their drive enables for the shared lines. A side lowers its enable before the other side is allowed to drive, so the two enables are never high together. The memory side starts its read when it captures the address. The read therefore runs in parallel with the release half of the request handshake. The data can appear only after both that release and the read latency have finished.

Top module: `hs_read_link`

## Requirements
- R1: While reset is low, `read_req`, `data_rdy`, `ack`, `req_oe`, `rsp_oe` and `done` are low, and `ready` is high.
- R2: A `start` sampled high on a `clk_req` edge while `ready` is high makes `read_req` and `req_oe` high from that edge onward. From the same edge, `bus` carries the zero-extended `addr`.
- R3: Each accepted read ends with `done` high for exactly one `clk_req` cycle. During that cycle, `rdata` holds the memory word for the address. The word is the low DW bits of (addr × 0x2D71) XOR 0xA5C3.
- R4: `req_oe` and `rsp_oe` are never high at the same time.
- R5: While `read_req` is held high, or while `data_rdy` is held high, `bus` does not change.
- R6: `read_req` and `data_rdy` are never high at the same time.
- R7: A `start` given while `ready` is low is ignored. It produces no extra `done` and does not alter `rdata`.
- R8: At least LAT `clk_rsp` cycles pass between the rise of `read_req` and the rise of `data_rdy`.
- R9: `ack` rises only while `read_req` or `data_rdy` is high.
- R10: `ready` returns high only after `ack` and `data_rdy` are both low. A new read may start in the first cycle `ready` is high, and it completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Local clock of the initiating side |
| clk_rsp | input | 1 | Local clock of the memory side |
| rst_n | input | 1 | Active-low asynchronous reset for both sides |
| start | input | 1 | Request to begin a read (clk_req domain) |
| addr | input | AW | Read address, sampled with start |
| ready | output | 1 | Initiating side idle and the lines are quiet |
| done | output | 1 | One-cycle pulse when read data is captured |
| rdata | output | DW | Last word captured |
| read_req | output | 1 | Read-request control line |
| data_rdy | output | 1 | Data-ready control line |
| ack | output | 1 | Shared acknowledge line (OR of both sides) |
| req_oe | output | 1 | Initiating side drives the shared lines |
| rsp_oe | output | 1 | Memory side drives the shared lines |
| bus | output | DW | Resolved value of the shared address/data lines |

## Verification
The hardest situation to reach is a `start` that arrives while a read is in flight. In that state the initiating side must ignore it, even though its inputs look like a valid request. The stimulus injects such a stray `start` with a different address partway through selected reads, both directed and at random. It then confirms that only one `done` appears and that the returned word matches the first address. A second hard case is the restart edge, where stale synchronized copies of `ack` could be mistaken for fresh ones. Back-to-back reads that start in the first cycle `ready` is high reach this case.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_ADDR,
        RQ_REL,
        RQ_WAIT,
        RQ_ACK
    } rq_state_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_ACK,
        RS_WAIT,
        RS_DRIVE,
        RS_DONE
    } rs_state_e;

    // Content of the modelled memory: a fixed scramble of the address.
    function automatic logic [31:0] mem_pattern(input logic [31:0] a);
        return (a * 32'h0000_2D71) ^ 32'h0000_A5C3;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/hs_mem_model.sv
module hs_mem_model #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int LAT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] addr,
    output logic          valid,
    output logic [DW-1:0] word
);
    import hs_pkg::*;

    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic [DW-1:0] word;
    } mem_regs_t;

    mem_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (launch) begin
            r_d.cnt  = '0;
            r_d.busy = 1'b1;
            r_d.word = DW'(mem_pattern(32'(addr)));
        end else if (r_q.busy && r_q.cnt != CW'(LAT)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid = r_q.busy && (r_q.cnt == CW'(LAT));
    assign word  = r_q.word;
endmodule

// File: rtl/hs_requester.sv
module hs_requester #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          ack_s,
    input  logic          drdy_s,
    input  logic [DW-1:0] bus_in,
    output logic          read_req,
    output logic          oe,
    output logic [DW-1:0] drive,
    output logic          ack_out,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata
);
    import hs_pkg::*;

    typedef struct packed {
        rq_state_e     st;
        logic          rreq;
        logic          oe;
        logic [DW-1:0] drv;
        logic          ack;
        logic          done;
        logic [DW-1:0] rdata;
    } rq_regs_t;

    rq_regs_t r_d, r_q;
    logic     idle_quiet;

    assign idle_quiet = (r_q.st == RQ_IDLE) && !ack_s && !drdy_s;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            RQ_IDLE: if (start && idle_quiet) begin
                r_d.st   = RQ_ADDR;
                r_d.rreq = 1'b1;
                r_d.oe   = 1'b1;
                r_d.drv  = DW'(addr);
            end
            RQ_ADDR: if (ack_s) begin
                r_d.st   = RQ_REL;
                r_d.rreq = 1'b0;
                r_d.oe   = 1'b0;
            end
            RQ_REL: if (!ack_s) r_d.st = RQ_WAIT;
            RQ_WAIT: if (drdy_s) begin
                r_d.st    = RQ_ACK;
                r_d.rdata = bus_in;
                r_d.ack   = 1'b1;
                r_d.done  = 1'b1;
            end
            RQ_ACK: if (!drdy_s) begin
                r_d.st  = RQ_IDLE;
                r_d.ack = 1'b0;
            end
            default: r_d.st = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RQ_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign read_req = r_q.rreq;
    assign oe       = r_q.oe;
    assign drive    = r_q.drv;
    assign ack_out  = r_q.ack;
    assign ready    = idle_quiet;
    assign done     = r_q.done;
    assign rdata    = r_q.rdata;
endmodule

// File: rtl/hs_responder.sv
module hs_responder #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int LAT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rreq_s,
    input  logic          ack_s,
    input  logic [DW-1:0] bus_in,
    output logic          data_rdy,
    output logic          oe,
    output logic [DW-1:0] drive,
    output logic          ack_out
);
    import hs_pkg::*;

    typedef struct packed {
        rs_state_e     st;
        logic          ack;
        logic          drdy;
        logic          oe;
        logic [DW-1:0] drv;
    } rs_regs_t;

    rs_regs_t      r_d, r_q;
    logic          launch;
    logic          mem_valid;
    logic [DW-1:0] mem_word;

    assign launch = (r_q.st == RS_IDLE) && rreq_s;

    hs_mem_model #(.AW(AW), .DW(DW), .LAT(LAT)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .addr  (bus_in[AW-1:0]),
        .valid (mem_valid),
        .word  (mem_word)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RS_IDLE: if (rreq_s) begin
                r_d.st  = RS_ACK;
                r_d.ack = 1'b1;
            end
            RS_ACK: if (!rreq_s) begin
                r_d.st  = RS_WAIT;
                r_d.ack = 1'b0;
            end
            // own ack echo must clear before a fresh ack can be trusted
            RS_WAIT: if (mem_valid && !ack_s) begin
                r_d.st   = RS_DRIVE;
                r_d.drv  = mem_word;
                r_d.drdy = 1'b1;
                r_d.oe   = 1'b1;
            end
            RS_DRIVE: if (ack_s) begin
                r_d.st   = RS_DONE;
                r_d.drdy = 1'b0;
                r_d.oe   = 1'b0;
            end
            RS_DONE: if (!ack_s) r_d.st = RS_IDLE;
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RS_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign data_rdy = r_q.drdy;
    assign oe       = r_q.oe;
    assign drive    = r_q.drv;
    assign ack_out  = r_q.ack;
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int LAT = 12
) (
    input  logic          clk_req,
    input  logic          clk_rsp,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          read_req,
    output logic          data_rdy,
    output logic          ack,
    output logic          req_oe,
    output logic          rsp_oe,
    output logic [DW-1:0] bus
);
    logic [DW-1:0] rq_drive;
    logic [DW-1:0] rs_drive;
    logic          rq_ack;
    logic          rs_ack;
    logic [1:0]    rq_seen;   // {ack, data_rdy} in clk_req domain
    logic [1:0]    rs_seen;   // {read_req, ack} in clk_rsp domain

    assign ack = rq_ack | rs_ack;
    assign bus = req_oe ? rq_drive : (rsp_oe ? rs_drive : '0);

    hs_sync #(.W(2)) u_sync_rq (
        .clk  (clk_req),
        .rst_n(rst_n),
        .d    ({ack, data_rdy}),
        .q    (rq_seen)
    );

    hs_sync #(.W(2)) u_sync_rs (
        .clk  (clk_rsp),
        .rst_n(rst_n),
        .d    ({read_req, ack}),
        .q    (rs_seen)
    );

    hs_requester #(.AW(AW), .DW(DW)) u_rq (
        .clk     (clk_req),
        .rst_n   (rst_n),
        .start   (start),
        .addr    (addr),
        .ack_s   (rq_seen[1]),
        .drdy_s  (rq_seen[0]),
        .bus_in  (bus),
        .read_req(read_req),
        .oe      (req_oe),
        .drive   (rq_drive),
        .ack_out (rq_ack),
        .ready   (ready),
        .done    (done),
        .rdata   (rdata)
    );

    hs_responder #(.AW(AW), .DW(DW), .LAT(LAT)) u_rs (
        .clk     (clk_rsp),
        .rst_n   (rst_n),
        .rreq_s  (rs_seen[1]),
        .ack_s   (rs_seen[0]),
        .bus_in  (bus),
        .data_rdy(data_rdy),
        .oe      (rsp_oe),
        .drive   (rs_drive),
        .ack_out (rs_ack)
    );
endmodule

// File: rtl/hs_read_link_chk.sv
module hs_read_link_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk_req,
    input logic          clk_rsp,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] addr,
    input logic          ready,
    input logic          done,
    input logic          read_req,
    input logic          data_rdy,
    input logic          ack,
    input logic          req_oe,
    input logic          rsp_oe,
    input logic [DW-1:0] bus
);
    // R2
    a_r2_addr_launch: assert property (@(posedge clk_req) disable iff (!rst_n)
        (start && ready) |=> (read_req && req_oe && bus == DW'($past(addr))));

    // R3
    a_r3_done_single: assert property (@(posedge clk_req) disable iff (!rst_n)
        done |=> !done);

    // R4
    a_r4_no_dual_drive_req: assert property (@(posedge clk_req) disable iff (!rst_n)
        !(req_oe && rsp_oe));
    a_r4_no_dual_drive_rsp: assert property (@(posedge clk_rsp) disable iff (!rst_n)
        !(req_oe && rsp_oe));

    // R5
    a_r5_addr_steady: assert property (@(posedge clk_req) disable iff (!rst_n)
        (read_req && $past(read_req)) |-> $stable(bus));
    a_r5_data_steady: assert property (@(posedge clk_rsp) disable iff (!rst_n)
        (data_rdy && $past(data_rdy)) |-> $stable(bus));

    // R6
    a_r6_interlock: assert property (@(posedge clk_req) disable iff (!rst_n)
        !(read_req && data_rdy));

    // R9
    a_r9_ack_has_cause: assert property (@(posedge clk_rsp) disable iff (!rst_n)
        $rose(ack) |-> (read_req || data_rdy));

    // R10
    a_r10_ready_quiet: assert property (@(posedge clk_req) disable iff (!rst_n)
        $rose(ready) |-> (!read_req && !data_rdy));
endmodule

bind hs_read_link hs_read_link_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_req (clk_req),
    .clk_rsp (clk_rsp),
    .rst_n   (rst_n),
    .start   (start),
    .addr    (addr),
    .ready   (ready),
    .done    (done),
    .read_req(read_req),
    .data_rdy(data_rdy),
    .ack     (ack),
    .req_oe  (req_oe),
    .rsp_oe  (rsp_oe),
    .bus     (bus)
);

// File: tb/test_hs_read_link.sv
module test_hs_read_link;
    localparam int CLK_PERIOD = 10;
    localparam int RSP_HALF   = 7;
    localparam int AW         = 8;
    localparam int DW         = 16;
    localparam int LAT        = 12;

    logic          clk_req = 1'b0;
    logic          clk_rsp = 1'b0;
    logic          rst_n   = 1'b0;
    logic          start   = 1'b0;
    logic [AW-1:0] addr    = '0;
    logic          ready, done, read_req, data_rdy, ack, req_oe, rsp_oe;
    logic [DW-1:0] rdata, bus;

    int checks   = 0;
    int fails    = 0;
    int reads    = 0;
    int done_cnt = 0;
    int last_lat = 0;
    bit dual_seen  = 1'b0;
    bit clash_seen = 1'b0;

    always #(CLK_PERIOD/2) clk_req = ~clk_req;
    always #(RSP_HALF) clk_rsp = ~clk_rsp;

    hs_read_link #(.AW(AW), .DW(DW), .LAT(LAT)) i_hs_read_link (
        .clk_req(clk_req), .clk_rsp(clk_rsp), .rst_n(rst_n),
        .start(start), .addr(addr), .ready(ready), .done(done),
        .rdata(rdata), .read_req(read_req), .data_rdy(data_rdy),
        .ack(ack), .req_oe(req_oe), .rsp_oe(rsp_oe), .bus(bus)
    );

    function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
        logic [31:0] p;
        p = (32'(a) * 32'h0000_2D71) ^ 32'h0000_A5C3;
        return p[DW-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // continuous observation of drive overlap and control interlock
    always @(negedge clk_req) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && req_oe && rsp_oe) dual_seen = 1'b1;
        if (rst_n && read_req && data_rdy) clash_seen = 1'b1;
    end
    always @(negedge clk_rsp) if (rst_n && req_oe && rsp_oe) dual_seen = 1'b1;

    // latency from read_req rise to data_rdy rise, in clk_rsp cycles
    initial forever begin
        int n;
        @(posedge read_req);
        n = 0;
        while (!data_rdy) begin
            @(posedge clk_rsp);
            n++;
        end
        last_lat = n;
    end

    task automatic do_read(input logic [AW-1:0] a, input bit poke, input int poke_at);
        int w;
        int dn0;
        w = 0;
        while (!ready && w < 2000) begin
            @(negedge clk_req);
            w++;
        end
        // R10: ready only with quiet control lines
        check(ready && !ack && !data_rdy && !read_req, "R10", "ready with quiet lines",
              {ready, ack, data_rdy, read_req}, 4'b1000);
        dn0 = done_cnt;
        start = 1'b1;
        addr  = a;
        @(negedge clk_req);
        start = 1'b0;
        reads++;
        check(read_req && req_oe && bus == DW'(a), "R2", "address launch",
              {read_req, req_oe, bus}, {2'b11, DW'(a)});
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk_req);
            w++;
            if (poke && w == poke_at && !done) begin
                check(!ready, "R7", "ready low during read", ready, 0);
                start = 1'b1;
                addr  = ~a;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(done == 1'b1, "R3", "done seen", done, 1);
        check(rdata == expect_word(a), "R3", "read word", rdata, expect_word(a));
        @(negedge clk_req);
        check(!done, "R3", "done single pulse", done, 0);
        check(last_lat >= LAT, "R8", "read latency", last_lat, LAT);
        if (poke) begin
            check(done_cnt == dn0 + 1, "R7", "no extra done", done_cnt - dn0, 1);
            check(rdata == expect_word(a), "R7", "word unchanged", rdata, expect_word(a));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk_req);
        // R1 reset state
        check(!read_req && !data_rdy && !ack, "R1", "controls in reset",
              {read_req, data_rdy, ack}, 0);
        check(!req_oe && !rsp_oe && !done, "R1", "enables in reset",
              {req_oe, rsp_oe, done}, 0);
        check(ready, "R1", "ready in reset", ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_req);

        // directed corners
        do_read('0, 1'b0, 0);
        do_read('1, 1'b0, 0);
        do_read(8'hAA, 1'b0, 0);   // R10 back-to-back restarts
        do_read(8'h55, 1'b0, 0);
        do_read(8'h3C, 1'b1, 5);   // R7 stray start early
        do_read(8'hC3, 1'b1, 30);  // R7 stray start late

        // constrained random
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] ra;
            int gap;
            ra  = AW'($urandom_range(0, (1 << AW) - 1));
            gap = $urandom_range(0, 4);
            repeat (gap) @(negedge clk_req);
            do_read(ra, ($urandom_range(0, 3) == 0), $urandom_range(2, 40));
        end

        repeat (10) @(negedge clk_req);
        check(!dual_seen, "R4", "never both enables", dual_seen, 0);
        check(!clash_seen, "R6", "read_req and data_rdy apart", clash_seen, 0);
        check(done_cnt == reads, "R7", "done count", done_cnt, reads);
        check(!ack && !read_req && !data_rdy && ready, "R9", "lines idle at end",
              {ack, read_req, data_rdy, ready}, 4'b0001);
        summary();
        $finish;
    end
endmodule